// File: doc/BRIEF.md
# Synchronous Character-Link Transmit Fault Controller

This block sits between a source of transmit bytes and the serial shifter of a character-oriented synchronous link. It walks through one transmit buffer at a time. A start strobe opens the buffer. Bytes then pass to the shifter each time the shifter asks for one. The byte flagged as last closes the buffer with clean status.

The block watches for two faults while a buffer is open. The first is starvation: the shifter asks for a byte and the source has none. The second is loss of the clear-to-send line. On either fault the block stops feeding the shifter and closes the buffer with a status bit naming the cause. It also pulses a transmit-error interrupt when that interrupt is enabled. After that it stays halted until a restart command arrives.

Starvation is not a fault when no buffer is open. It is also not a fault while a transparent-mode escape pair is in flight. Clear-to-send is taken through a synchronizer before it is checked.

Top module: `bsc_txf_ctrl`

## Requirements
- R1: Synchronous reset (active high) leaves the block idle. `tx_busy`, `tx_halted`, `tx_load`, `close_stb`, `close_un`, `close_ct`, `txe_irq` and `src_ready` are all 0.
- R2: While a buffer is open and synchronized CTS is high, `src_ready` follows `shf_req`. A clock edge with `shf_req`, `src_ready` and `src_valid` all high makes `tx_load` 1 for one cycle after that edge, with `tx_byte` equal to the accepted `src_data`.
- R3: Accepting a byte with `src_last` high closes the buffer cleanly. One cycle after that edge, `close_stb`=1, `close_un`=0, `close_ct`=0 and `txe_irq`=0, and the block is idle again.
- R4: Starvation while a buffer is open is an underrun unless it is protected (see R7). Starvation means `shf_req` high with `src_valid` low. One cycle after the edge where it happens, `close_stb`=1, `close_un`=1 and `close_ct`=0, and `tx_halted`=1.
- R5: `txe_irq` pulses together with a fault close (underrun or CTS loss) only if `irq_en` was high at that edge. A fault close with `irq_en` low still reports its status bit.
- R6: Starvation while idle raises no underrun and no close.
- R7: When `xparent_mode`=1 and `dle_pair`=1, starvation is not an underrun and the buffer stays open. With `xparent_mode`=0, `dle_pair` has no effect.
- R8: When `cts_in` falls while a buffer is open, the buffer closes on the third clock edge after the fall, with `close_stb`=1 and `close_ct`=1. The three edges are two synchronizer stages plus the state register. If a starvation happens on that same edge, CTS loss takes priority and `close_un` stays 0.
- R9: While halted, the block ignores `buf_start`, holds `src_ready` at 0 and never asserts `tx_load`. A `restart` strobe returns it to idle one cycle later.
- R10: A `restart` strobe while idle or while a buffer is open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| buf_start | input | 1 | Strobe that opens a transmit buffer when idle |
| src_valid | input | 1 | Source has a byte available |
| src_data | input | DW | Byte from the source |
| src_last | input | 1 | Marks the offered byte as the last of the buffer |
| src_ready | output | 1 | Block takes the offered byte this cycle |
| shf_req | input | 1 | Shifter asks for the next byte |
| cts_in | input | 1 | Clear-to-send, asynchronous, high = clear |
| xparent_mode | input | 1 | Transparent mode selected |
| dle_pair | input | 1 | An escape character has been sent and its partner is pending |
| restart | input | 1 | Restart-transmit command strobe |
| irq_en | input | 1 | Transmit-error interrupt enable |
| tx_load | output | 1 | One-cycle strobe: `tx_byte` is valid for the shifter |
| tx_byte | output | DW | Byte handed to the shifter |
| close_stb | output | 1 | One-cycle buffer-closed strobe |
| close_un | output | 1 | Underrun status, valid with `close_stb` |
| close_ct | output | 1 | CTS-lost status, valid with `close_stb` |
| txe_irq | output | 1 | One-cycle transmit-error interrupt pulse |
| tx_busy | output | 1 | A buffer is open |
| tx_halted | output | 1 | Halted after a fault, waiting for restart |

## Verification
The shifter-side results come one cycle after the edge that samples the stimulus. These are a byte load, a clean close, an underrun close and the return to idle after a restart. The bench drives each stimulus right after a falling edge and reads results at the next falling edge. The CTS-lost close comes on the third edge after `cts_in` falls. The bench reads the close strobe after each of the first three edges, requires it low after the first two and high after the third, and adds a starvation on that third edge to test priority. The ignore cases (starvation while idle, protected escape pairs, inputs while halted, a restart outside a halt) are checked over several cycles at the close, load and status ports.

// File: rtl/bsc_txf_pkg.sv
package bsc_txf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEND    = 2'd1,
    ST_HALT_UN = 2'd2,
    ST_HALT_CT = 2'd3
  } txf_state_e;

  typedef struct packed {
    logic stb;
    logic un;
    logic ct;
    logic irq;
  } close_info_t;
endpackage

// File: rtl/bsc_cts_sync.sv
module bsc_cts_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bsc_txf_fsm.sv
module bsc_txf_fsm
  import bsc_txf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        buf_start,
  input  logic        shf_req,
  input  logic        src_valid,
  input  logic        src_last,
  input  logic        cts_ok,
  input  logic        xparent_mode,
  input  logic        dle_pair,
  input  logic        restart,
  input  logic        irq_en,
  output txf_state_e  state,
  output logic        take,
  output close_info_t close_nxt
);
  txf_state_e state_nxt;
  logic       guarded;

  assign guarded = xparent_mode && dle_pair;
  assign take    = (state == ST_SEND) && shf_req && cts_ok;

  always_comb begin
    state_nxt = state;
    close_nxt = '0;
    unique case (state)
      ST_IDLE: begin
        if (buf_start) state_nxt = ST_SEND;
      end
      ST_SEND: begin
        if (!cts_ok) begin
          state_nxt     = ST_HALT_CT;
          close_nxt.stb = 1'b1;
          close_nxt.ct  = 1'b1;
          close_nxt.irq = irq_en;
        end else if (shf_req) begin
          if (src_valid) begin
            if (src_last) begin
              state_nxt     = ST_IDLE;
              close_nxt.stb = 1'b1;
            end
          end else if (!guarded) begin
            state_nxt     = ST_HALT_UN;
            close_nxt.stb = 1'b1;
            close_nxt.un  = 1'b1;
            close_nxt.irq = irq_en;
          end
        end
      end
      ST_HALT_UN, ST_HALT_CT: begin
        if (restart) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nxt;
  end
endmodule

// File: rtl/bsc_txf_out.sv
module bsc_txf_out
  import bsc_txf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [DW-1:0] din,
  input  close_info_t   close_nxt,
  output logic          tx_load,
  output logic [DW-1:0] tx_byte,
  output close_info_t   close_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_load <= 1'b0;
      tx_byte <= '0;
      close_q <= '0;
    end else begin
      tx_load <= fire;
      if (fire) tx_byte <= din;
      close_q <= close_nxt;
    end
  end
endmodule

// File: rtl/bsc_txf_ctrl.sv
module bsc_txf_ctrl
  import bsc_txf_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          buf_start,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  input  logic          src_last,
  output logic          src_ready,
  input  logic          shf_req,
  input  logic          cts_in,
  input  logic          xparent_mode,
  input  logic          dle_pair,
  input  logic          restart,
  input  logic          irq_en,
  output logic          tx_load,
  output logic [DW-1:0] tx_byte,
  output logic          close_stb,
  output logic          close_un,
  output logic          close_ct,
  output logic          txe_irq,
  output logic          tx_busy,
  output logic          tx_halted
);
  logic        cts_ok;
  logic        take;
  txf_state_e  state;
  close_info_t close_nxt;
  close_info_t close_q;

  bsc_cts_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (cts_in),
    .dout(cts_ok)
  );

  bsc_txf_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .buf_start   (buf_start),
    .shf_req     (shf_req),
    .src_valid   (src_valid),
    .src_last    (src_last),
    .cts_ok      (cts_ok),
    .xparent_mode(xparent_mode),
    .dle_pair    (dle_pair),
    .restart     (restart),
    .irq_en      (irq_en),
    .state       (state),
    .take        (take),
    .close_nxt   (close_nxt)
  );

  bsc_txf_out #(.DW(DW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .fire     (take && src_valid),
    .din      (src_data),
    .close_nxt(close_nxt),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .close_q  (close_q)
  );

  assign src_ready = take;
  assign close_stb = close_q.stb;
  assign close_un  = close_q.un;
  assign close_ct  = close_q.ct;
  assign txe_irq   = close_q.irq;
  assign tx_busy   = (state == ST_SEND);
  assign tx_halted = (state == ST_HALT_UN) || (state == ST_HALT_CT);
endmodule

// File: rtl/bsc_txf_chk.sv
module bsc_txf_chk (
  input logic clk,
  input logic rst,
  input logic shf_req,
  input logic src_valid,
  input logic xparent_mode,
  input logic dle_pair,
  input logic restart,
  input logic irq_en,
  input logic tx_load,
  input logic close_stb,
  input logic close_un,
  input logic close_ct,
  input logic txe_irq,
  input logic tx_busy,
  input logic tx_halted
);
  // R4 / R8: a close never names both causes, and status only rides on the strobe
  a_r4_single_cause: assert property (@(posedge clk) disable iff (rst)
    close_stb |-> !(close_un && close_ct));
  a_r4_status_needs_stb: assert property (@(posedge clk) disable iff (rst)
    !close_stb |-> (!close_un && !close_ct));

  // R4 / R6 / R7: an underrun needs an open buffer, unprotected starvation
  a_r6_un_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    close_un |-> $past(tx_busy) && $past(shf_req) && !$past(src_valid));
  a_r7_un_not_in_pair: assert property (@(posedge clk) disable iff (rst)
    close_un |-> !($past(xparent_mode) && $past(dle_pair)));

  // R5: interrupt only on a fault close, and only when enabled
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
    txe_irq |-> $past(irq_en) && close_stb && (close_un || close_ct));

  // R9: halt holds until restart, restart leaves it, no loads while halted
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (tx_halted && !restart) |=> tx_halted);
  a_r9_restart_exits: assert property (@(posedge clk) disable iff (rst)
    (tx_halted && restart) |=> (!tx_halted && !tx_busy));
  a_r9_no_load_halted: assert property (@(posedge clk) disable iff (rst)
    tx_halted |=> !tx_load);

  // R4 / R8: a fault close lands in the halted state
  a_r8_fault_halts: assert property (@(posedge clk) disable iff (rst)
    (close_un || close_ct) |-> tx_halted);
endmodule

bind bsc_txf_ctrl bsc_txf_chk u_chk (.*);

// File: tb/bsc_txf_ctrl_tb.sv
module bsc_txf_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int WDOG       = 5000;

  logic          clk = 1'b0;
  logic          rst;
  logic          buf_start, src_valid, src_last, shf_req, cts_in;
  logic          xparent_mode, dle_pair, restart, irq_en;
  logic [DW-1:0] src_data;
  logic          src_ready, tx_load, close_stb, close_un, close_ct;
  logic          txe_irq, tx_busy, tx_halted;
  logic [DW-1:0] tx_byte;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsc_txf_ctrl #(.DW(DW)) u_dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    buf_start = 0; src_valid = 0; src_last = 0; shf_req = 0;
    restart = 0; src_data = '0;
  endtask

  task automatic open_buf();
    buf_start = 1; step(); buf_start = 0;
    chk("R2", "busy after start", tx_busy, 1);
  endtask

  task automatic do_restart();
    restart = 1; step(); restart = 0;
    chk("R9", "halted after restart", tx_halted, 0);
    chk("R9", "busy after restart", tx_busy, 0);
  endtask

  task automatic t_reset();
    idle_inputs(); cts_in = 1; xparent_mode = 0; dle_pair = 0; irq_en = 1;
    rst = 1; step(); step(); rst = 0;
    chk("R1", "busy", tx_busy, 0);
    chk("R1", "halted", tx_halted, 0);
    chk("R1", "close/load/irq", {close_stb, close_un, close_ct, txe_irq, tx_load}, 0);
    chk("R1", "src_ready", src_ready, 0);
    repeat (4) step();
  endtask

  task automatic t_transfer();
    open_buf();
    for (int i = 0; i < 3; i++) begin
      shf_req = 1; src_valid = 1; src_data = 8'h41 + 8'(i); src_last = (i == 2);
      #1;
      chk("R2", "src_ready with request", src_ready, 1);
      step();
      shf_req = 0; src_valid = 0; src_last = 0;
      chk("R2", "tx_load", tx_load, 1);
      chk("R2", "tx_byte", tx_byte, 8'h41 + 8'(i));
      if (i < 2) chk("R2", "no close mid buffer", close_stb, 0);
      else begin
        chk("R3", "clean close", {close_stb, close_un, close_ct, txe_irq}, 4'b1000);
        chk("R3", "idle after close", tx_busy, 0);
      end
    end
    step();
    chk("R2", "load is one pulse", tx_load, 0);
  endtask

  task automatic t_idle_starve();
    shf_req = 1; src_valid = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R6", "no close while idle", {close_stb, close_un}, 0);
      chk("R6", "not halted", tx_halted, 0);
    end
    shf_req = 0;
    restart = 1; step(); restart = 0;
    chk("R10", "restart idle ignored", {tx_busy, tx_halted, close_stb}, 0);
  endtask

  task automatic t_underrun(input logic en);
    irq_en = en;
    open_buf();
    shf_req = 1; src_valid = 0; step(); shf_req = 0;
    chk("R4", "underrun close", {close_stb, close_un, close_ct}, 3'b110);
    chk("R4", "halted", tx_halted, 1);
    chk("R5", "irq follows enable", txe_irq, en);
    step();
    chk("R5", "irq one pulse", {txe_irq, close_stb}, 0);
    buf_start = 1; shf_req = 1; src_valid = 1; src_data = 8'h99;
    #1;
    chk("R9", "src_ready low halted", src_ready, 0);
    repeat (2) begin
      step();
      chk("R9", "no load halted", tx_load, 0);
      chk("R9", "still halted", {tx_halted, tx_busy}, 2'b10);
    end
    idle_inputs();
    do_restart();
    irq_en = 1;
  endtask

  task automatic t_dle_pair();
    xparent_mode = 1; dle_pair = 1;
    open_buf();
    shf_req = 1; src_valid = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7", "pair protects", {close_stb, tx_halted}, 0);
      chk("R7", "buffer stays open", tx_busy, 1);
    end
    dle_pair = 0; step(); shf_req = 0;
    chk("R7", "underrun after pair", {close_stb, close_un}, 2'b11);
    do_restart();
    xparent_mode = 0; dle_pair = 1;
    open_buf();
    shf_req = 1; step(); shf_req = 0;
    chk("R7", "pair flag ignored non-transparent", {close_stb, close_un}, 2'b11);
    dle_pair = 0;
    do_restart();
  endtask

  task automatic t_cts_loss();
    open_buf();
    cts_in = 0;
    for (int e = 1; e <= 2; e++) begin
      step();
      chk("R8", "no close before third edge", close_stb, 0);
    end
    shf_req = 1; src_valid = 0;
    step(); shf_req = 0;
    chk("R8", "cts close on third edge", {close_stb, close_ct, close_un}, 3'b110);
    chk("R5", "cts irq", txe_irq, 1);
    chk("R8", "halted", tx_halted, 1);
    cts_in = 1; repeat (3) step();
    chk("R9", "halt survives cts return", tx_halted, 1);
    do_restart();
  endtask

  task automatic t_restart_sending();
    open_buf();
    restart = 1; step(); restart = 0;
    chk("R10", "restart while sending ignored", tx_busy, 1);
    shf_req = 1; src_valid = 1; src_last = 1; src_data = 8'h5A;
    step(); idle_inputs();
    chk("R10", "buffer closes cleanly", {close_stb, close_un, close_ct}, 3'b100);
    chk("R10", "byte passed", tx_byte, 8'h5A);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_transfer();
    t_idle_starve();
    t_underrun(1'b1);
    t_underrun(1'b0);
    t_dle_pair();
    t_cts_loss();
    t_restart_sending();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule